// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block gathers the event strobes of one DMA channel into a 12-bit interrupt status register and drives a single level interrupt towards the processor. Software reaches it over a simple 32-bit register port. It can clear status bits by writing ones to them. It can unmask sources through an enable port and mask them through a disable port. The mask itself is read-only, so software never has to read, modify and write it back.

Two 8-bit accounting counters record how many source and destination descriptors have completed since software last looked. Reading a counter returns its value and clears it. If a counter rolls over, a dedicated status bit is raised so that lost counts are visible. An access to any offset this block does not implement raises the invalid-access status bit.

Top module: `dmairq_ctrl`

Register offsets (byte addresses): 0x00 status (write 1 to clear), 0x04 mask (read-only), 0x08 enable, 0x0C disable, 0x10 source count, 0x14 destination count. Any other value of `reg_addr`, including an unaligned one, is unimplemented. Status and mask bit positions: 11 pause, 10 done, 9 write-data error, 8 read-data error, 7 destination-descriptor fetch error, 6 source-descriptor fetch error, 5 destination-count overflow, 4 source-count overflow, 3 byte-count overflow, 2 destination-descriptor done, 1 source-descriptor done, 0 invalid access.

## Requirements
- R1: After reset the status reads 0x000, the mask reads 0xFFF, both counters read 0 and `irq` is low.
- R2: A one-cycle pulse on `evt_other[k]` sets status bit 3 for k=0 and status bit 5+k for k=1..6. Writing 1 to a status bit clears it, writing 0 leaves it, and bits 31:12 read as zero.
- R3: Writing 1 to a bit at the enable offset clears that mask bit. Writing 1 at the disable offset sets it. A write to the mask offset leaves the mask unchanged.
- R4: The enable and disable offsets read back as zero.
- R5: `irq` is high exactly when some status bit is set whose mask bit is clear. It follows a status or mask change on the same clock edge that updates the register.
- R6: Each `evt_src_done` pulse increments the source count and sets status bit 1. A pulse arriving while the count is 255 wraps it to 0 and also sets bit 4. `evt_dst_done` does the same with the destination count, bit 2 and bit 5.
- R7: A read of a count returns its value and clears it. A done pulse in the same cycle as that read leaves the count at 1 afterwards.
- R8: A read or write at an unimplemented offset sets status bit 0, returns zero on reads and changes no other state.
- R9: When an event sets a status bit in the same cycle as a write clears it, the bit ends up set.
- R10: Read data appears on `reg_rdata` in the cycle after the read is presented, and is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| evt_src_done | input | 1 | Source descriptor completed, one-cycle pulse |
| evt_dst_done | input | 1 | Destination descriptor completed, one-cycle pulse |
| evt_other | input | 7 | Other channel events, one-cycle pulses (mapping in R2) |
| irq | output | 1 | Registered level interrupt |

## Verification
All seven general event lines are first pulsed together with every source masked. This separates setting a status bit from raising `irq`. Single-bit enable, clear and disable writes then show that each port touches only its own bit.

Runs of 3, 255 and 256 completions tell normal counting from the wrap and its overflow flag. Two cases are presented in the same cycle: a clearing write with a set event, and a counter read with a completion. Together they pin down which side wins.

Accesses at unimplemented and unaligned offsets are followed by reads of the status, the mask and a counter. These show that only the invalid-access bit moved.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int unsigned NUM_EV   = 12;
    localparam int unsigned OTHER_N  = 7;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W_D = 8;
    localparam int unsigned CNT_W_D  = 8;

    // Status bit positions
    localparam int unsigned B_INVALID  = 0;
    localparam int unsigned B_SRC_DONE = 1;
    localparam int unsigned B_DST_DONE = 2;
    localparam int unsigned B_SRC_OVF  = 4;
    localparam int unsigned B_DST_OVF  = 5;

    // Status bit driven by each general event line
    localparam int unsigned OTHER_POS [OTHER_N] = '{3, 6, 7, 8, 9, 10, 11};

    // Register byte offsets
    localparam int unsigned OFF_STAT = 'h00;
    localparam int unsigned OFF_MASK = 'h04;
    localparam int unsigned OFF_IEN  = 'h08;
    localparam int unsigned OFF_IDS  = 'h0C;
    localparam int unsigned OFF_SCNT = 'h10;
    localparam int unsigned OFF_DCNT = 'h14;

    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_MASK,
        SEL_IEN,
        SEL_IDS,
        SEL_SCNT,
        SEL_DCNT,
        SEL_NONE
    } reg_target_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        reg_target_e target;
    } reg_acc_t;

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_D
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_acc_t          acc_o
);

    always_comb begin
        acc_o.rd = sel_i & ~wr_i;
        acc_o.wr = sel_i & wr_i;
        if      (addr_i == ADDR_W'(OFF_STAT)) acc_o.target = SEL_STAT;
        else if (addr_i == ADDR_W'(OFF_MASK)) acc_o.target = SEL_MASK;
        else if (addr_i == ADDR_W'(OFF_IEN))  acc_o.target = SEL_IEN;
        else if (addr_i == ADDR_W'(OFF_IDS))  acc_o.target = SEL_IDS;
        else if (addr_i == ADDR_W'(OFF_SCNT)) acc_o.target = SEL_SCNT;
        else if (addr_i == ADDR_W'(OFF_DCNT)) acc_o.target = SEL_DCNT;
        else                                  acc_o.target = SEL_NONE;
    end

endmodule

// File: rtl/dmairq_acct.sv
module dmairq_acct #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;

    // A clearing read and a completion together leave one count
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= inc_i ? CNT_W'(1) : '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = inc_i & ~clr_i & (cnt_q == '1);

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !inc_i) |=> (cnt_q == '0)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_D,
    parameter int unsigned CNT_W  = CNT_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              evt_src_done,
    input  logic              evt_dst_done,
    input  logic [OTHER_N-1:0] evt_other,
    output logic              irq
);

    localparam int unsigned SIDES = 2;

    reg_acc_t          acc;
    logic              inv_acc;
    logic [NUM_EV-1:0] stat_q, stat_d, mask_q, mask_d;
    logic [NUM_EV-1:0] w1c, ien, ids, set_v;
    logic [DATA_W-1:0] rdata_d;
    logic [SIDES-1:0]  side_inc, side_clr, side_wrap;
    logic [CNT_W-1:0]  side_cnt [SIDES];
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_EV];

    dmairq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel_i  (reg_sel),
        .wr_i   (reg_wr),
        .addr_i (reg_addr),
        .acc_o  (acc)
    );

    assign side_inc = {evt_dst_done, evt_src_done};
    assign side_clr = {acc.rd && acc.target == SEL_DCNT,
                       acc.rd && acc.target == SEL_SCNT};

    for (genvar g = 0; g < SIDES; g++) begin : g_acct
        dmairq_acct #(.CNT_W(CNT_W)) u_acct (
            .clk    (clk),
            .rst    (rst),
            .inc_i  (side_inc[g]),
            .clr_i  (side_clr[g]),
            .cnt_o  (side_cnt[g]),
            .wrap_o (side_wrap[g])
        );
    end

    assign inv_acc = (acc.rd | acc.wr) && acc.target == SEL_NONE;
    assign w1c = (acc.wr && acc.target == SEL_STAT) ? reg_wdata[NUM_EV-1:0] : '0;
    assign ien = (acc.wr && acc.target == SEL_IEN)  ? reg_wdata[NUM_EV-1:0] : '0;
    assign ids = (acc.wr && acc.target == SEL_IDS)  ? reg_wdata[NUM_EV-1:0] : '0;

    always_comb begin
        set_v = '0;
        for (int i = 0; i < OTHER_N; i++)
            set_v[OTHER_POS[i]] = evt_other[i];
        set_v[B_SRC_DONE] = evt_src_done;
        set_v[B_DST_DONE] = evt_dst_done;
        set_v[B_SRC_OVF]  = side_wrap[0];
        set_v[B_DST_OVF]  = side_wrap[1];
        set_v[B_INVALID]  = inv_acc;
    end

    // Setting takes precedence over clearing
    assign stat_d = (stat_q & ~w1c) | set_v;
    assign mask_d = (mask_q & ~ien) | ids;

    always_comb begin
        rdata_d = '0;
        if (acc.rd) begin
            case (acc.target)
                SEL_STAT: rdata_d = DATA_W'(stat_q);
                SEL_MASK: rdata_d = DATA_W'(mask_q);
                SEL_SCNT: rdata_d = DATA_W'(side_cnt[0]);
                SEL_DCNT: rdata_d = DATA_W'(side_cnt[1]);
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            mask_q    <= '1;
            irq       <= 1'b0;
            reg_rdata <= '0;
        end else begin
            stat_q    <= stat_d;
            mask_q    <= mask_d;
            irq       <= |(stat_d & ~mask_d);
            reg_rdata <= rdata_d;
        end
    end

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq == |(stat_q & ~mask_q)); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_q & $past(w1c & ~set_v)) == '0); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (~stat_q & $past(set_v)) == '0); // R9

    AST_MASK_PORTS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ien == '0 && ids == '0) |=> $stable(mask_q)); // R3

    AST_INVALID_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.target == SEL_NONE) |=> (reg_rdata == '0)); // R8

    AST_INVALID_FLAG: assert property (@(posedge clk) disable iff (rst)
        inv_acc |=> stat_q[B_INVALID]); // R8

endmodule

// File: tb/tb_dmairq_ctrl.sv
module tb_dmairq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ev_src = 1'b0;
    logic        ev_dst = 1'b0;
    logic [6:0]  ev_oth = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    dmairq_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .reg_sel      (sel),
        .reg_wr       (wr),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .evt_src_done (ev_src),
        .evt_dst_done (ev_dst),
        .evt_other    (ev_oth),
        .irq          (irq)
    );

    // Monitor: a read seen at a rising edge delivers data at the following edge
    always @(posedge clk) rd_seen <= sel & ~wr & ~rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected read data actual %h expected none", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic d, input logic [6:0] o, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_src = s; ev_dst = d; ev_oth = o;
            @(negedge clk);
            ev_src = 1'b0; ev_dst = 1'b0; ev_oth = '0;
        end
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_irq(1'b0, "R1 reset irq");
        reg_read(8'h00, 32'h000, "R1 reset status");
        reg_read(8'h04, 32'hFFF, "R1 reset mask");
        reg_read(8'h10, 32'h000, "R1 reset src count");
        reg_read(8'h14, 32'h000, "R1 reset dst count");

        // All general events while fully masked
        pulse(1'b0, 1'b0, 7'h7F, 1);
        chk_irq(1'b0, "R5 masked events keep irq low");
        reg_read(8'h00, 32'hFC8, "R2 event to status mapping");

        reg_write(8'h08, 32'h400);
        chk_irq(1'b1, "R5 enable done raises irq");
        reg_read(8'h04, 32'hBFF, "R3 enable clears one mask bit");
        reg_read(8'h08, 32'h000, "R4 enable port reads zero");
        reg_read(8'h0C, 32'h000, "R4 disable port reads zero");

        reg_write(8'h00, 32'h400);
        chk_irq(1'b0, "R5 clearing status drops irq");
        reg_read(8'h00, 32'hBC8, "R2 write one clears only that bit");

        reg_write(8'h0C, 32'h400);
        reg_write(8'h04, 32'h000);
        reg_read(8'h04, 32'hFFF, "R3 disable sets, mask offset write ignored");
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, 32'h000, "R2 clear all status");

        pulse(1'b1, 1'b0, 7'h00, 3);
        reg_read(8'h10, 32'h003, "R6 source count after three");
        reg_read(8'h10, 32'h000, "R7 source count cleared by read");
        pulse(1'b0, 1'b1, 7'h00, 1);
        reg_read(8'h00, 32'h006, "R6 done bits set");
        reg_read(8'h14, 32'h001, "R6 destination count");

        // Clear and set of bit 1 in the same cycle
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'h00; wdata = 32'h002; ev_src = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; ev_src = 1'b0;
        reg_read(8'h00, 32'h006, "R9 set beats clear");

        pulse(1'b1, 1'b0, 7'h00, 1);
        // Read count (2) while another completion arrives
        exp_q.push_back(32'h002);
        tag_q.push_back("R7 read with completion returns old value");
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 8'h10; ev_src = 1'b1;
        @(negedge clk);
        sel = 1'b0; ev_src = 1'b0;
        reg_read(8'h10, 32'h001, "R7 completion during read kept");

        reg_write(8'h00, 32'hFFF);
        pulse(1'b1, 1'b0, 7'h00, 255);
        reg_read(8'h00, 32'h002, "R6 no overflow at 255");
        pulse(1'b1, 1'b0, 7'h00, 1);
        reg_read(8'h00, 32'h012, "R6 source overflow flag");
        reg_read(8'h10, 32'h000, "R6 source count wrapped");
        pulse(1'b0, 1'b1, 7'h00, 256);
        reg_read(8'h00, 32'h036, "R6 destination overflow flag");
        reg_read(8'h14, 32'h000, "R6 destination count wrapped");
        reg_write(8'h08, 32'h010);
        chk_irq(1'b1, "R5 overflow source unmasked");

        reg_write(8'h0C, 32'hFFF);
        reg_write(8'h00, 32'hFFF);
        chk_irq(1'b0, "R5 all masked and clear");
        reg_write(8'h08, 32'h001);
        reg_read(8'h18, 32'h000, "R8 unimplemented read returns zero");
        chk_irq(1'b1, "R8 invalid access raises irq");
        reg_read(8'h00, 32'h001, "R8 invalid bit set");
        reg_write(8'h20, 32'hFFF);
        reg_read(8'h04, 32'hFFE, "R8 invalid write leaves mask");
        reg_read(8'h00, 32'h001, "R8 invalid write leaves status");
        reg_read(8'h02, 32'h000, "R8 unaligned read returns zero");
        reg_read(8'h10, 32'h000, "R8 counters untouched");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule